// File: doc/BRIEF.md
# Cubic Fit Coefficient Unit

This unit characterises a digital-to-analog converter under test. It drives a ramp of input codes to the converter. For every code it takes one filtered measurement from the measuring path. It adds that measurement into one of four running sums, one for each quarter of the code range. When the ramp is complete, the unit folds the four sums into four coefficients of a cubic transfer model: offset, gain, second-order distortion and third-order distortion. Each coefficient is checked against its own lower and upper limit, and the unit raises a fail indication if any check fails.

The code axis is centred on the middle of the ramp, so the model is y = a0 + a1·u + a2·u² + a3·u³ with u = code − 2·L. L = 2^s is the section length, and s is given at start. Each reported coefficient is twelve times the model coefficient, in signed fixed point with FRAC_W fractional bits. This scaling keeps every constant in the fit a shift or a small add. The measurement filter and the analog modulator sit outside this block. The block only sees a sample and its valid strobe.

Top module: `cubic_fit_unit`

## Requirements
- R1: A `start` pulse while idle begins a run. From the next cycle `busy` is 1, `done` is 0, `ramp_code` is 0 and all four section sums are cleared.
- R2: While running, `ramp_code` advances by one for each cycle with `samp_valid` high and holds otherwise. A run accepts exactly 4·2^s samples. It then spends one compute cycle with `busy` still high.
- R3: The sample taken at code k is added to section sum S[k >> s], for sections 0 to 3.
- R4: The combinations are P0 = S0+S1+S2+S3, P1 = S3+S2−S1−S0, P2 = S3−S2−S1+S0 and P3 = S3−3·S2+3·S1−S0.
- R5: The coefficients are computed as follows, where `>>>` is an arithmetic right shift:
  - coefficient 0 = ((3·P0 − 4·P2)·2^FRAC_W) >>> s
  - coefficient 1 = ((3·P1 − 4·P3)·2^FRAC_W) >>> 2s
  - coefficient 2 = (3·P2·2^FRAC_W) >>> 3s
  - coefficient 3 = (2·P3·2^FRAC_W) >>> 4s
  
  Coefficient p is reported on `coef[p*COEF_W +: COEF_W]` in two's complement.
- R6: `done` rises at the clock edge after the compute cycle, in the same edge where `busy` falls. It stays high until the next accepted start. `coef` changes only at that edge.
- R7: `fail_flags[p]` is 1 when coefficient p is below `lim_lo[p*COEF_W +: COEF_W]` or above `lim_hi[p*COEF_W +: COEF_W]`. Both are compared signed, and both bounds are inclusive passes. The limits are sampled in the compute cycle. `fail` is the OR of the four flags.
- R8: A `start` pulse during a run has no effect, and neither does `samp_valid` outside a run. While idle, `ramp_code` is 0.
- R9: A `sec_log2` value above CODE_W−2 is clamped to CODE_W−2, so that a run never exceeds the full code range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a characterisation run |
| sec_log2 | input | SEL_W | log2 of the section length, sampled at start |
| samp_valid | input | 1 | Measurement sample strobe |
| samp_data | input | DATA_W | Signed measurement for the current ramp code |
| lim_lo | input | 4·COEF_W | Signed lower limit per coefficient |
| lim_hi | input | 4·COEF_W | Signed upper limit per coefficient |
| ramp_code | output | CODE_W | Code to apply to the converter under test |
| busy | output | 1 | Run or compute in progress |
| coef | output | 4·COEF_W | Four signed fixed-point coefficients |
| fail_flags | output | 4 | Per-coefficient limit violation |
| fail | output | 1 | Any limit violation |
| done | output | 1 | Results valid |

## Verification
A sample routed to the wrong section shows first in the distortion coefficients. For example, a single section's excitation leaks into the third-order term. This is visible at `done`, within one cycle after the last sample. A wrong shift amount or sign in the combining stage shows in the same cycle, as a coefficient off by a power of two or with a flipped sign. Random, single-section and pure-ramp patterns are used to separate these cases.

A code counter that slips shows on `ramp_code` at the next accepted sample. A wrong run length shows as `busy` falling early or late relative to the sample count.

// File: rtl/cubic_fit_unit.sv
module cubic_fit_unit #(
  parameter int CODE_W = 14,
  parameter int DATA_W = 16,
  parameter int COEF_W = 32,
  parameter int FRAC_W = 8,
  parameter int SEL_W  = $clog2(CODE_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [SEL_W-1:0]         sec_log2,
  input  logic                     samp_valid,
  input  logic signed [DATA_W-1:0] samp_data,
  input  logic [4*COEF_W-1:0]      lim_lo,
  input  logic [4*COEF_W-1:0]      lim_hi,
  output logic [CODE_W-1:0]        ramp_code,
  output logic                     busy,
  output logic [4*COEF_W-1:0]      coef,
  output logic [3:0]               fail_flags,
  output logic                     fail,
  output logic                     done
);
  localparam int ACC_W  = DATA_W + CODE_W;
  localparam int NUM_W  = ACC_W + 7;
  localparam int WIDE_W = NUM_W + FRAC_W;
  localparam int SH_W   = SEL_W + 2;
  localparam logic [SEL_W-1:0] MAX_S = SEL_W'(CODE_W - 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CALC} st_t;

  st_t                      st_q;
  logic [SEL_W-1:0]         s_q;
  logic [CODE_W-1:0]        code_q;
  logic [CODE_W-1:0]        last_code;
  logic [1:0]               sec;
  logic signed [ACC_W-1:0]  acc_q [4];
  logic signed [NUM_W-1:0]  sx [4];
  logic signed [NUM_W-1:0]  pc [4];
  logic signed [NUM_W-1:0]  num [4];
  logic [SH_W-1:0]          sh [4];
  logic signed [COEF_W-1:0] cf_d [4];
  logic signed [COEF_W-1:0] cf_q [4];
  logic [3:0]               flag_q;
  logic                     done_q;
  logic                     running;

  function automatic logic signed [COEF_W-1:0] scale(input logic signed [NUM_W-1:0] n,
                                                     input logic [SH_W-1:0] amt);
    logic signed [WIDE_W-1:0] w;
    w = WIDE_W'(n) <<< FRAC_W;
    w = w >>> amt;
    return COEF_W'(w);
  endfunction

  assign running   = (st_q == ST_RUN);
  assign busy      = (st_q != ST_IDLE);
  assign last_code = (CODE_W'(4) << s_q) - CODE_W'(1);
  assign sec       = 2'(code_q >> s_q);

  for (genvar i = 0; i < 4; i++) begin : g_ext
    assign sx[i] = NUM_W'(acc_q[i]);
  end

  assign pc[0] = sx[3] + sx[2] + sx[1] + sx[0];
  assign pc[1] = sx[3] + sx[2] - sx[1] - sx[0];
  assign pc[2] = sx[3] - sx[2] - sx[1] + sx[0];
  assign pc[3] = sx[3] - (sx[2] <<< 1) - sx[2] + (sx[1] <<< 1) + sx[1] - sx[0];

  assign num[0] = (pc[0] <<< 1) + pc[0] - (pc[2] <<< 2);
  assign num[1] = (pc[1] <<< 1) + pc[1] - (pc[3] <<< 2);
  assign num[2] = (pc[2] <<< 1) + pc[2];
  assign num[3] = pc[3] <<< 1;

  assign sh[0] = SH_W'(s_q);
  assign sh[1] = SH_W'(s_q) << 1;
  assign sh[2] = (SH_W'(s_q) << 1) + SH_W'(s_q);
  assign sh[3] = SH_W'(s_q) << 2;

  for (genvar p = 0; p < 4; p++) begin : g_coef
    assign cf_d[p] = scale(num[p], sh[p]);
    assign coef[p*COEF_W +: COEF_W] = cf_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      s_q    <= '0;
      code_q <= '0;
      flag_q <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < 4; i++) begin
        acc_q[i] <= '0;
        cf_q[i]  <= '0;
      end
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_RUN;
          s_q    <= (sec_log2 > MAX_S) ? MAX_S : sec_log2;
          code_q <= '0;
          done_q <= 1'b0;
          for (int i = 0; i < 4; i++) acc_q[i] <= '0;
        end
        ST_RUN: if (samp_valid) begin
          acc_q[sec] <= acc_q[sec] + ACC_W'(samp_data);
          if (code_q == last_code) begin
            code_q <= '0;
            st_q   <= ST_CALC;
          end else begin
            code_q <= code_q + CODE_W'(1);
          end
        end
        ST_CALC: begin
          for (int p = 0; p < 4; p++) begin
            cf_q[p]   <= cf_d[p];
            flag_q[p] <= (cf_d[p] < $signed(lim_lo[p*COEF_W +: COEF_W])) ||
                         (cf_d[p] > $signed(lim_hi[p*COEF_W +: COEF_W]));
          end
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ramp_code  = code_q;
  assign fail_flags = flag_q;
  assign fail       = |flag_q;
  assign done       = done_q;
endmodule

// File: rtl/fit_unit_checks.sv
module fit_unit_checks #(
  parameter int CODE_W = 14,
  parameter int COEF_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                samp_valid,
  input logic                running,
  input logic                busy,
  input logic                done,
  input logic [CODE_W-1:0]   ramp_code,
  input logic [4*COEF_W-1:0] coef
);
  assert_code_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running && samp_valid |=> (ramp_code == $past(ramp_code) + CODE_W'(1)) || (ramp_code == '0));

  assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running && !samp_valid |=> $stable(ramp_code) && busy);

  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ramp_code == '0);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running && start && !samp_valid |=> running && $stable(ramp_code));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_coef_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(coef) |-> $rose(done));
endmodule

bind cubic_fit_unit fit_unit_checks #(.CODE_W(CODE_W), .COEF_W(COEF_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .samp_valid(samp_valid), .running(running),
  .busy(busy), .done(done), .ramp_code(ramp_code), .coef(coef));

// File: tb/test_cubic_fit_unit.sv
module test_cubic_fit_unit;
  logic               clk = 0;
  logic               rst_n = 0;
  logic               start = 0;
  logic [3:0]         sec_log2 = 0;
  logic               samp_valid = 0;
  logic signed [15:0] samp_data = 0;
  logic [127:0]       lim_lo = 0;
  logic [127:0]       lim_hi = 0;
  logic [13:0]        ramp_code;
  logic               busy;
  logic [127:0]       coef;
  logic [3:0]         fail_flags;
  logic               fail;
  logic               done;

  int checks = 0;
  int failures = 0;
  longint last_exp [4];

  cubic_fit_unit i_cubic_fit_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .sec_log2(sec_log2), .samp_valid(samp_valid),
    .samp_data(samp_data), .lim_lo(lim_lo), .lim_hi(lim_hi), .ramp_code(ramp_code), .busy(busy),
    .coef(coef), .fail_flags(fail_flags), .fail(fail), .done(done));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gen(input int mode, input int k, input int s);
    case (mode)
      0: return 37 * k - 900;
      1: return int'($urandom_range(4000)) - 2000 + 3 * k;
      2: return ((k >> s) == 2) ? 1000 : 0;
      default: return k - 8192 + int'($urandom_range(127)) - 64;
    endcase
  endfunction

  function automatic longint exp_coef(input int p, input longint sm [4], input int s);
    longint pp0, pp1, pp2, pp3, n;
    int sh;
    pp0 = sm[0] + sm[1] + sm[2] + sm[3];
    pp1 = sm[3] + sm[2] - sm[1] - sm[0];
    pp2 = sm[3] - sm[2] - sm[1] + sm[0];
    pp3 = sm[3] - 3 * sm[2] + 3 * sm[1] - sm[0];
    case (p)
      0: n = 3 * pp0 - 4 * pp2;
      1: n = 3 * pp1 - 4 * pp3;
      2: n = 3 * pp2;
      default: n = 2 * pp3;
    endcase
    sh = (p + 1) * s;
    return (n <<< 8) >>> sh;
  endfunction

  task automatic run_ramp(input int s_in, input int mode, input int limcfg, input bit poke);
    int s;
    int total;
    int bad;
    int bad_act;
    int bad_exp;
    longint sm [4];
    longint ex [4];
    logic [3:0] exp_flags;
    string tag;
    s = (s_in > 12) ? 12 : s_in;
    total = 4 << s;
    bad = 0;
    bad_act = 0;
    bad_exp = 0;
    tag = (s_in > 12) ? "R9 clamped run length" : "R2 ramp sequence";
    for (int i = 0; i < 4; i++) sm[i] = 0;
    @(negedge clk);
    sec_log2 = 4'(s_in);
    start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    chk(busy && !done && ramp_code == 0, "R1 start state", {busy, done, 14'(ramp_code)}, 32'h8000);
    for (int k = 0; k < total; k++) begin
      if ($urandom_range(7) == 0) begin
        samp_data = 16'($urandom);
        @(posedge clk);
        @(negedge clk);
      end
      if (ramp_code != 14'(k) || !busy) begin
        if (bad == 0) begin
          bad_act = int'(ramp_code);
          bad_exp = k;
        end
        bad++;
      end
      begin
        int v;
        v = gen(mode, k, s);
        samp_valid = 1;
        samp_data = 16'(v);
        sm[k >> s] += longint'(v);
      end
      if (poke && k == total / 3) start = 1;
      @(posedge clk);
      @(negedge clk);
      samp_valid = 0;
      start = 0;
    end
    chk(bad == 0, tag, bad_act, bad_exp);
    if (poke) chk(bad == 0, "R8 start during run ignored", bad_act, bad_exp);
    chk(busy && !done, "R2 compute cycle", {busy, done}, 2'b10);
    for (int p = 0; p < 4; p++) ex[p] = exp_coef(p, sm, s);
    for (int p = 0; p < 4; p++) begin
      lim_lo[p*32 +: 32] = 32'h8000_0000;
      lim_hi[p*32 +: 32] = 32'h7fff_ffff;
      if (limcfg == 1) begin
        lim_lo[p*32 +: 32] = 32'(ex[p]);
        lim_hi[p*32 +: 32] = 32'(ex[p]);
      end
    end
    if (limcfg == 2) begin
      lim_lo[32 +: 32] = 32'(ex[1] + 1);
      lim_hi[96 +: 32] = 32'(ex[3] - 1);
    end
    for (int p = 0; p < 4; p++)
      exp_flags[p] = (ex[p] < longint'($signed(lim_lo[p*32 +: 32]))) ||
                     (ex[p] > longint'($signed(lim_hi[p*32 +: 32])));
    @(posedge clk);
    @(negedge clk);
    lim_lo = 0;
    lim_hi = 0;
    chk(done && !busy, "R6 done after compute", {done, busy}, 2'b10);
    for (int p = 0; p < 4; p++)
      chk(longint'($signed(coef[p*32 +: 32])) == ex[p], "R3 R4 R5 coefficient",
          longint'($signed(coef[p*32 +: 32])), ex[p]);
    chk(fail_flags == exp_flags, "R7 limit flags", fail_flags, exp_flags);
    chk(fail == (|exp_flags), "R7 fail", fail, |exp_flags);
    for (int p = 0; p < 4; p++) last_exp[p] = ex[p];
  endtask

  task automatic idle_poke();
    int bad;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      samp_valid = 1;
      samp_data = 16'($urandom);
      @(posedge clk);
      @(negedge clk);
      samp_valid = 0;
      if (ramp_code != 0 || !done || busy) bad++;
      for (int p = 0; p < 4; p++)
        if (longint'($signed(coef[p*32 +: 32])) != last_exp[p]) bad++;
    end
    chk(bad == 0, "R8 idle samples ignored, R6 results held", bad, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ramp_code == 0 && !busy && !done && !fail && coef == 0 && fail_flags == 0,
        "R1 reset state", {busy, done, fail}, 0);
    rst_n = 1;
    run_ramp(2, 0, 0, 0);
    idle_poke();
    run_ramp(5, 1, 0, 0);
    run_ramp(3, 0, 1, 1);
    run_ramp(4, 2, 2, 0);
    run_ramp(0, 1, 0, 0);
    run_ramp(12, 3, 0, 0);
    run_ramp(15, 3, 2, 0);
    idle_poke();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule